// File: doc/BRIEF.md
# Serial Key Program-Mode Entry Detector

This block sits on the device side of a serial programming port and decides whether the part may enter its program/verify mode. It watches three asynchronous pins: a control pin, a serial clock and a serial data line. A valid entry has three steps. First, the control pin gives a short high-then-low pulse. Second, after a hold-off counted in system clocks, a 32-bit key is shifted in on rising serial-clock edges. Third, the control pin is raised again and kept high. The mode is entered only when the captured word equals the fixed key.

While the mode is active the block asks the pad ring to put all unused I/Os in high impedance. After a further settling count it opens a window in which downstream logic may act on serial data. Dropping the control pin ends the mode at once. An attempt that goes wrong sets a sticky error flag, which the next control-pin pulse clears.

All three pins pass through a two-flop synchronizer, and serial-clock rising edges are found from the synchronized copy. The state machine has these states:
- `ST_IDLE`: waiting for the pin to rise.
- `ST_PULSE`: pin high, waiting for it to fall.
- `ST_GAP`: hold-off before key bits are honoured.
- `ST_SHIFT`: collecting key bits.
- `ST_SETTLE`: mode on, data window still shut.
- `ST_ACTIVE`: mode on, data window open.
- `ST_FAULT`: a failed attempt, waiting for the pin to drop.

The state machine has these transitions:
- IDLE→PULSE on pin high, which also clears the error.
- PULSE→GAP on pin low.
- GAP→SHIFT when the hold-off expires.
- GAP→FAULT on pin high during the hold-off.
- SHIFT→SETTLE on pin high with a correct key.
- SHIFT→FAULT on pin high with a wrong or mis-sized key, or on timeout.
- SETTLE→ACTIVE when the settling count expires.
- SETTLE/ACTIVE→IDLE on pin low.
- FAULT→IDLE on pin low.

Top module: `serial_key_entry`

## Requirements
- R1: After reset, mode_active, data_window_open, hiz_req and key_error are all 0.
- R2: Key bits shifted in and a pin rise without a preceding high-then-low pulse on ctl_pin never set mode_active.
- R3: The key is 32'h4D434850, taken most significant bit first (the first bit shifted is bit 31). That key followed by a pin rise sets mode_active, and the same key sent in bit-reversed order does not.
- R4: A captured word that differs from the key in any bit (for example, bit 0 flipped) leaves mode_active at 0 and sets key_error to 1.
- R5: Raising ctl_pin after fewer than 32 or more than 32 serial-clock rising edges leaves mode_active at 0 and sets key_error to 1.
- R6: If ctl_pin is not raised within TIMEOUT_CYC system clocks of the shift phase opening, the attempt is discarded with key_error set to 1, and a later pin rise does not set mode_active.
- R7: Serial-clock edges that arrive during the GAP_CYC hold-off after the pulse falls are ignored, so a key that follows them still enters the mode.
- R8: mode_active stays 1 while ctl_pin stays high and returns to 0 within 4 system clocks of ctl_pin falling.
- R9: data_window_open rises exactly SETTLE_CYC system clocks after mode_active rises, and is never 1 while mode_active is 0.
- R10: hiz_req equals mode_active.
- R11: key_error stays 1 after a failure, whatever the pin level, until the next rise of ctl_pin from idle clears it.
- R12: Raising ctl_pin before the hold-off after the pulse has expired sets key_error to 1 and does not set mode_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_pin | input | 1 | Control pin (asynchronous) |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| mode_active | output | 1 | Program/verify mode entered |
| data_window_open | output | 1 | Serial data may be honoured |
| hiz_req | output | 1 | Request to float unused I/Os |
| key_error | output | 1 | Sticky failed-entry flag |

## Verification
Some rules are checked by the assertions on every cycle:
- the data window never opens outside the mode;
- the mode falls one cycle after the synchronized pin falls;
- the mode rises only from a full-length word equal to the key;
- an error never appears while the mode is on;
- the bit counter never runs past the key length;
- the capture register holds still whenever shifting is disabled.

Other behaviours depend on whole pin sequences and only the bench scenarios can show them:
- the exact settling delay;
- the hold-off discarding early edges;
- bit order;
- the timeout;
- the stickiness and clearing of the error flag.

// File: rtl/entry_pkg.sv
package entry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_GAP,
        ST_SHIFT,
        ST_SETTLE,
        ST_ACTIVE,
        ST_FAULT
    } entry_state_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                if (s == 0) begin
                    stage_q[s] <= d_async;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    end

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/key_shifter.sv
module key_shifter #(
    parameter int KEY_BITS = 32,
    localparam int CNT_W   = $clog2(KEY_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic                bit_stb,
    input  logic                bit_val,
    output logic [KEY_BITS-1:0] word,
    output logic [CNT_W-1:0]    cnt,
    output logic                ovf
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
            ovf  <= 1'b0;
        end else if (clr) begin
            word <= '0;
            cnt  <= '0;
            ovf  <= 1'b0;
        end else if (en && bit_stb) begin
            if (cnt == CNT_W'(KEY_BITS)) begin
                ovf <= 1'b1;
            end else begin
                word <= {word[KEY_BITS-2:0], bit_val};
                cnt  <= cnt + 1'b1;
            end
        end
    end

    // Counter saturates at the key length (R5)
    assert_cnt_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(KEY_BITS));

    // Edges outside the shift phase leave the capture alone (R7)
    assert_word_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(word));
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
    import entry_pkg::*;
#(
    parameter int              KEY_BITS    = 32,
    parameter logic [KEY_BITS-1:0] KEY     = 32'h4D434850,
    parameter int              GAP_CYC     = 64,
    parameter int              SETTLE_CYC  = 128,
    parameter int              TIMEOUT_CYC = 100000,
    localparam int             CNT_W       = $clog2(KEY_BITS + 1),
    localparam int             M1          = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC,
    localparam int             M2          = (M1 > TIMEOUT_CYC) ? M1 : TIMEOUT_CYC,
    localparam int             TMR_W       = $clog2(M2 + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_s,
    input  logic [KEY_BITS-1:0] key_word,
    input  logic [CNT_W-1:0]    bit_cnt,
    input  logic                bit_ovf,
    output logic                shift_en,
    output logic                shift_clr,
    output logic                mode_active,
    output logic                data_window_open,
    output logic                hiz_req,
    output logic                key_error
);
    entry_state_t state_q, state_d;
    logic [TMR_W-1:0] tmr_q;
    logic             err_set, err_clr, key_ok;

    assign key_ok = (bit_cnt == CNT_W'(KEY_BITS)) && !bit_ovf && (key_word == KEY);

    always_comb begin
        state_d = state_q;
        err_set = 1'b0;
        err_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ctl_s) begin
                    state_d = ST_PULSE;
                    err_clr = 1'b1;
                end
            end
            ST_PULSE: begin
                if (!ctl_s) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (ctl_s) begin
                    state_d = ST_FAULT;
                    err_set = 1'b1;
                end else if (tmr_q == TMR_W'(GAP_CYC - 1)) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (ctl_s) begin
                    if (key_ok) begin
                        state_d = ST_SETTLE;
                    end else begin
                        state_d = ST_FAULT;
                        err_set = 1'b1;
                    end
                end else if (tmr_q == TMR_W'(TIMEOUT_CYC - 1)) begin
                    state_d = ST_FAULT;
                    err_set = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!ctl_s) state_d = ST_IDLE;
                else if (tmr_q == TMR_W'(SETTLE_CYC - 1)) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!ctl_s) state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (!ctl_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tmr_q     <= '0;
            key_error <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) tmr_q <= '0;
            else if (tmr_q != '1)   tmr_q <= tmr_q + 1'b1;
            if (err_set)      key_error <= 1'b1;
            else if (err_clr) key_error <= 1'b0;
        end
    end

    always_comb begin
        shift_clr        = (state_q == ST_PULSE);
        shift_en         = (state_q == ST_SHIFT);
        mode_active      = (state_q == ST_SETTLE) || (state_q == ST_ACTIVE);
        data_window_open = (state_q == ST_ACTIVE);
        hiz_req          = (state_q == ST_SETTLE) || (state_q == ST_ACTIVE);
    end

    assert_window_in_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_window_open |-> mode_active);

    assert_pin_drop_exits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_s) |=> !mode_active);

    assert_entry_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_active) |-> ($past(key_word) == KEY && $past(bit_cnt) == CNT_W'(KEY_BITS)));

    assert_no_error_in_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_error) |-> !mode_active);
endmodule

// File: rtl/serial_key_entry.sv
module serial_key_entry #(
    parameter int KEY_BITS    = 32,
    parameter logic [KEY_BITS-1:0] KEY = 32'h4D434850,
    parameter int SYNC_STAGES = 2,
    parameter int GAP_CYC     = 64,
    parameter int SETTLE_CYC  = 128,
    parameter int TIMEOUT_CYC = 100000,
    localparam int CNT_W      = $clog2(KEY_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_pin,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic mode_active,
    output logic data_window_open,
    output logic hiz_req,
    output logic key_error
);
    logic [2:0]          pins_s;
    logic                ctl_s, sclk_s, sdat_s, sclk_q, bit_stb;
    logic                shift_en, shift_clr, bit_ovf;
    logic [KEY_BITS-1:0] key_word;
    logic [CNT_W-1:0]    bit_cnt;

    sync_chain #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({ctl_pin, ser_clk, ser_dat}),
        .d_sync (pins_s)
    );

    assign {ctl_s, sclk_s, sdat_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign bit_stb = sclk_s & ~sclk_q;

    key_shifter #(.KEY_BITS(KEY_BITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (shift_clr),
        .en     (shift_en),
        .bit_stb(bit_stb),
        .bit_val(sdat_s),
        .word   (key_word),
        .cnt    (bit_cnt),
        .ovf    (bit_ovf)
    );

    entry_fsm #(
        .KEY_BITS   (KEY_BITS),
        .KEY        (KEY),
        .GAP_CYC    (GAP_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctl_s           (ctl_s),
        .key_word        (key_word),
        .bit_cnt         (bit_cnt),
        .bit_ovf         (bit_ovf),
        .shift_en        (shift_en),
        .shift_clr       (shift_clr),
        .mode_active     (mode_active),
        .data_window_open(data_window_open),
        .hiz_req         (hiz_req),
        .key_error       (key_error)
    );
endmodule

// File: tb/serial_key_entry_tb.sv
module serial_key_entry_tb;
    localparam int GAP    = 16;
    localparam int SETTLE = 24;
    localparam int TOUT   = 600;
    localparam logic [31:0] KEYV = 32'h4D434850;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_pin = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic mode_active, data_window_open, hiz_req, key_error;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    typedef struct {
        string tag;
        bit    mode;
        bit    win;
        bit    err;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    serial_key_entry #(
        .GAP_CYC(GAP), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TOUT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .mode_active(mode_active),
        .data_window_open(data_window_open), .hiz_req(hiz_req),
        .key_error(key_error)
    );

    task automatic check_val(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check_val({e.tag, " mode"}, int'(mode_active), int'(e.mode));
                check_val({e.tag, " window"}, int'(data_window_open), int'(e.win));
                check_val({e.tag, " error"}, int'(key_error), int'(e.err));
                check_val({e.tag, " hiz"}, int'(hiz_req), int'(e.mode));
            end
        end
    end

    task automatic expect_out(string tag, bit m, bit w, bit e);
        exp_t x;
        x.tag = tag; x.mode = m; x.win = w; x.err = e;
        exp_q.push_back(x);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ctl_pin = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic pulse();
        ctl_pin = 1'b1; wait_clk(5);
        ctl_pin = 1'b0;
    endtask

    task automatic send_bits(logic [63:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i]; wait_clk(3);
            ser_clk = 1'b1; wait_clk(3);
            ser_clk = 1'b0; wait_clk(3);
        end
    endtask

    function automatic logic [31:0] bitrev(logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31 - i];
        return r;
    endfunction

    task automatic attempt(logic [63:0] v, int n);
        pulse();
        wait_clk(GAP + 8);
        send_bits(v, n);
        ctl_pin = 1'b1;
        wait_clk(SETTLE + 10);
    endtask

    initial begin
        do_reset();
        expect_out("R1 reset", 0, 0, 0);

        // R3 / R9 / R10 / R8: good key, measure settling delay
        pulse();
        wait_clk(GAP + 8);
        send_bits({32'h0, KEYV}, 32);
        ctl_pin = 1'b1;
        begin
            int m_at = -1, w_at = -1;
            for (int c = 0; c < SETTLE + 40; c++) begin
                @(negedge clk);
                if (mode_active && m_at < 0) m_at = c;
                if (data_window_open && w_at < 0) w_at = c;
                if (data_window_open && !mode_active) check_val("R9 window without mode", 1, 0);
            end
            check_val("R9 settle delay", w_at - m_at, SETTLE);
        end
        expect_out("R3 R10 key accepted", 1, 1, 0);
        wait_clk(100);
        expect_out("R8 held high", 1, 1, 0);
        ctl_pin = 1'b0;
        wait_clk(4);
        expect_out("R8 pin dropped", 0, 0, 0);

        // R4: bit 0 flipped
        do_reset();
        attempt({32'h0, KEYV ^ 32'h1}, 32);
        expect_out("R4 wrong key", 0, 0, 1);

        // R11: sticky across pin levels, cleared by next pulse
        wait_clk(50);
        expect_out("R11 sticky pin high", 0, 0, 1);
        ctl_pin = 1'b0; wait_clk(20);
        expect_out("R11 sticky pin low", 0, 0, 1);
        pulse(); wait_clk(6);
        expect_out("R11 cleared by pulse", 0, 0, 0);

        // R3: bit-reversed order rejected
        do_reset();
        attempt({32'h0, bitrev(KEYV)}, 32);
        expect_out("R3 reversed order", 0, 0, 1);

        // R5: short and long keys
        do_reset();
        attempt({33'h0, KEYV[31:1]}, 31);
        expect_out("R5 31 bits", 0, 0, 1);
        do_reset();
        attempt({31'h0, KEYV, 1'b0}, 33);
        expect_out("R5 33 bits", 0, 0, 1);

        // R6: timeout
        do_reset();
        pulse();
        wait_clk(GAP + 8);
        send_bits({32'h0, KEYV}, 32);
        wait_clk(TOUT);
        expect_out("R6 timeout error", 0, 0, 1);
        ctl_pin = 1'b1; wait_clk(SETTLE + 10);
        expect_out("R6 late rise no mode", 0, 0, 0);

        // R2: key and rise without pulse
        do_reset();
        send_bits({32'h0, KEYV}, 32);
        ctl_pin = 1'b1; wait_clk(SETTLE + 10);
        expect_out("R2 no pulse", 0, 0, 0);

        // R7: edge inside hold-off ignored
        do_reset();
        pulse();
        wait_clk(1);
        send_bits(64'h1, 1);
        wait_clk(GAP + 8);
        send_bits({32'h0, KEYV}, 32);
        ctl_pin = 1'b1; wait_clk(SETTLE + 10);
        expect_out("R7 early edge ignored", 1, 1, 0);

        // R12: pin rises during hold-off
        do_reset();
        pulse();
        wait_clk(4);
        ctl_pin = 1'b1; wait_clk(SETTLE + 10);
        expect_out("R12 early rise", 0, 0, 1);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        wait_clk(3);
        if (!done) check_val("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule